// File: doc/BRIEF.md
# Banked Data Memory with Indirect Access

This block is the data-memory front end of an 8-bit microcontroller core. It takes an 8-bit direct address with read, write and single-bit set or clear strobes. It resolves that address to one of three things: a special-function location below 40H, a byte of general-purpose RAM in the 40H–FFH region, or nothing at all. It then performs the access in one clock.

Two addresses have no storage of their own. Instead, each forwards the access to the location held in a companion 8-bit pointer register, so software can walk tables without changing code. The general-purpose region is replicated three times. A 2-bit field in a bank register picks the copy that is visible, while everything below 40H stays common to all banks. The ALU, real peripheral registers and instruction decode are outside this block. Special-function locations other than the pointers and the bank register behave as plain byte storage.

Top module: `bdm_core`

## Requirements
- R1: After reset every special-function location, including both pointers (01H, 03H) and the bank register (04H), reads 00H.
- R2: Locations 01H and 03H are the two 8-bit pointers; a direct write stores all 8 bits and a direct read returns them.
- R3: A direct access to 00H acts on the location whose address is held in 01H, and a direct access to 02H acts on the location whose address is held in 03H; this applies to reads, writes and bit operations.
- R4: A read through either window whose pointer holds 00H or 02H returns 00H.
- R5: A write or bit operation through either window whose pointer holds 00H or 02H changes no location.
- R6: Bits 1..0 of 04H select the visible RAM copy for 40H–FFH: 00 gives bank 0, 01 gives bank 1, 10 gives bank 2; bits 7..2 do not affect selection; each bank holds 192 independent bytes.
- R7: Bank code 11 acts as bank 0 for reads and writes.
- R8: Locations 01H–3FH (other than 02H) are common storage whose contents do not depend on the bank code.
- R9: With bit_set high and wr_en low, bit bit_sel of the target is set to 1 on the clock edge and the other seven bits keep their values.
- R10: With bit_clr high, and both wr_en and bit_set low, bit bit_sel of the target is cleared and the other bits keep their values.
- R11: Priority is wr_en over bit_set over bit_clr when more than one is high in a cycle.
- R12: With rd_en high, rdata follows the current address and stored state in the same cycle; with rd_en low, rdata is 00H. Writes take effect at the rising clock edge.
- R13: When a window pointer holds an address of 40H or above, the access uses the bank selected by 04H at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of special-function storage |
| addr | input | 8 | Direct data-memory address |
| rd_en | input | 1 | Read strobe; gates rdata |
| wr_en | input | 1 | Whole-byte write strobe |
| wdata | input | 8 | Write data |
| bit_set | input | 1 | Set one bit of the target |
| bit_clr | input | 1 | Clear one bit of the target |
| bit_sel | input | 3 | Bit index for set or clear |
| rdata | output | 8 | Read data of the resolved target |

## Verification
The bench sweeps every pointer value through both windows. This catches a design that recurses through a window pointing at a window, or that returns stale data in place of 00H, or that stores a null write into a pointer. It fills all three banks with distinct arithmetic patterns and reads each back under every bank code. A design that aliases banks, ignores bank code 11, or lets the upper bank-register bits leak into selection then shows wrong bytes. Single-bit set and clear are walked over all eight bit positions, both directly and through a window, together with the strobe priority cases. A design with a bad mask or a wrong priority then alters neighbouring bits or keeps the wrong value.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    localparam int DM_ADDR_W    = 8;
    localparam int DM_DATA_W    = 8;
    localparam int DM_BANK_W    = 2;
    localparam int DM_NUM_BANKS = 3;
    localparam int DM_GPR_BASE  = 64;
    localparam int DM_SFR_IW    = $clog2(DM_GPR_BASE);
    localparam int DM_GPR_DEPTH = (1 << DM_ADDR_W) - DM_GPR_BASE;
    localparam int DM_GPR_IW    = $clog2(DM_GPR_DEPTH);
    localparam int DM_BIT_W     = $clog2(DM_DATA_W);

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SFR  = 2'd1,
        TGT_GPR  = 2'd2
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e              kind;
        logic [DM_SFR_IW-1:0]   sfr_idx;
        logic [DM_BANK_W-1:0]   bank;
        logic [DM_GPR_IW-1:0]   gpr_idx;
    } tgt_t;
endpackage

// File: rtl/bdm_decode.sv
module bdm_decode
    import bdm_pkg::*;
#(
    parameter logic [DM_ADDR_W-1:0] WIN0 = 8'h00,
    parameter logic [DM_ADDR_W-1:0] WIN1 = 8'h02
) (
    input  logic [DM_ADDR_W-1:0] addr,
    input  logic [DM_ADDR_W-1:0] ptr0,
    input  logic [DM_ADDR_W-1:0] ptr1,
    input  logic [DM_BANK_W-1:0] bank_sel,
    output tgt_t                 tgt
);
    logic [DM_ADDR_W-1:0] eff_addr;

    // First stage: follow a window to its pointer (one level only).
    always_comb begin
        if (addr == WIN0)      eff_addr = ptr0;
        else if (addr == WIN1) eff_addr = ptr1;
        else                   eff_addr = addr;
    end

    // Second stage: classify the effective address.
    always_comb begin
        tgt = '0;
        tgt.kind = TGT_NONE;
        if (eff_addr == WIN0 || eff_addr == WIN1) begin
            tgt.kind = TGT_NONE;
        end else if (int'(eff_addr) >= DM_GPR_BASE) begin
            tgt.kind    = TGT_GPR;
            tgt.gpr_idx = DM_GPR_IW'(eff_addr - DM_ADDR_W'(DM_GPR_BASE));
            tgt.bank    = (int'(bank_sel) < DM_NUM_BANKS) ? bank_sel : '0;
        end else begin
            tgt.kind    = TGT_SFR;
            tgt.sfr_idx = eff_addr[DM_SFR_IW-1:0];
        end
    end
endmodule

// File: rtl/bdm_sfr_file.sv
module bdm_sfr_file
    import bdm_pkg::*;
#(
    parameter int NUM_LOC = DM_GPR_BASE,
    parameter int WIN0    = 0,
    parameter int WIN1    = 2,
    parameter int PTR0    = 1,
    parameter int PTR1    = 3,
    parameter int BANKREG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [DM_SFR_IW-1:0] idx,
    input  logic [DM_DATA_W-1:0] wdata,
    output logic [DM_DATA_W-1:0] rdata,
    output logic [DM_ADDR_W-1:0] ptr0_q,
    output logic [DM_ADDR_W-1:0] ptr1_q,
    output logic [DM_BANK_W-1:0] bank_q
);
    logic [NUM_LOC-1:0][DM_DATA_W-1:0] cell_vec;

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        if (i == WIN0 || i == WIN1) begin : g_hole
            assign cell_vec[i] = '0;
        end else begin : g_reg
            logic [DM_DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               q <= '0;
                else if (we && idx == DM_SFR_IW'(i))      q <= wdata;
            end
            assign cell_vec[i] = q;
        end
    end

    assign rdata  = cell_vec[idx];
    assign ptr0_q = DM_ADDR_W'(cell_vec[PTR0]);
    assign ptr1_q = DM_ADDR_W'(cell_vec[PTR1]);
    assign bank_q = cell_vec[BANKREG][DM_BANK_W-1:0];
endmodule

// File: rtl/bdm_gpr_banks.sv
module bdm_gpr_banks
    import bdm_pkg::*;
#(
    parameter int NUM_BANKS = DM_NUM_BANKS,
    parameter int DEPTH     = DM_GPR_DEPTH
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [DM_BANK_W-1:0] bank,
    input  logic [DM_GPR_IW-1:0] idx,
    input  logic [DM_DATA_W-1:0] wdata,
    output logic [DM_DATA_W-1:0] rdata
);
    logic [NUM_BANKS-1:0][DM_DATA_W-1:0] bank_rd;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DM_DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && int'(bank) == b) mem[idx] <= wdata;
        end
        assign bank_rd[b] = mem[idx];
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank) == b) rdata = bank_rd[b];
        end
    end
endmodule

// File: rtl/bdm_core.sv
module bdm_core
    import bdm_pkg::*;
#(
    parameter logic [DM_ADDR_W-1:0] WIN0_ADDR = 8'h00,
    parameter logic [DM_ADDR_W-1:0] WIN1_ADDR = 8'h02,
    parameter int                   PTR0_ADDR = 1,
    parameter int                   PTR1_ADDR = 3,
    parameter int                   BANK_ADDR = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DM_ADDR_W-1:0] addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [DM_DATA_W-1:0] wdata,
    input  logic                 bit_set,
    input  logic                 bit_clr,
    input  logic [DM_BIT_W-1:0]  bit_sel,
    output logic [DM_DATA_W-1:0] rdata
);
    logic [DM_ADDR_W-1:0] mp0_q, mp1_q;
    logic [DM_BANK_W-1:0] bp_q;
    tgt_t                 tgt;
    logic [DM_DATA_W-1:0] sfr_rd, gpr_rd, cur_val, nxt_val, bit_mask;
    logic                 any_wr, sfr_we, gpr_we;

    bdm_decode #(.WIN0(WIN0_ADDR), .WIN1(WIN1_ADDR)) u_dec (
        .addr     (addr),
        .ptr0     (mp0_q),
        .ptr1     (mp1_q),
        .bank_sel (bp_q),
        .tgt      (tgt)
    );

    always_comb begin
        unique case (tgt.kind)
            TGT_SFR: cur_val = sfr_rd;
            TGT_GPR: cur_val = gpr_rd;
            default: cur_val = '0;
        endcase
    end

    assign bit_mask = DM_DATA_W'(1) << bit_sel;

    always_comb begin
        if (wr_en)        nxt_val = wdata;
        else if (bit_set) nxt_val = cur_val | bit_mask;
        else              nxt_val = cur_val & ~bit_mask;
    end

    assign any_wr = wr_en | bit_set | bit_clr;
    assign sfr_we = any_wr && (tgt.kind == TGT_SFR);
    assign gpr_we = any_wr && (tgt.kind == TGT_GPR);

    bdm_sfr_file #(
        .NUM_LOC (DM_GPR_BASE),
        .WIN0    (int'(WIN0_ADDR)),
        .WIN1    (int'(WIN1_ADDR)),
        .PTR0    (PTR0_ADDR),
        .PTR1    (PTR1_ADDR),
        .BANKREG (BANK_ADDR)
    ) u_sfr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sfr_we),
        .idx    (tgt.sfr_idx),
        .wdata  (nxt_val),
        .rdata  (sfr_rd),
        .ptr0_q (mp0_q),
        .ptr1_q (mp1_q),
        .bank_q (bp_q)
    );

    bdm_gpr_banks #(.NUM_BANKS(DM_NUM_BANKS), .DEPTH(DM_GPR_DEPTH)) u_gpr (
        .clk   (clk),
        .we    (gpr_we),
        .bank  (tgt.bank),
        .idx   (tgt.gpr_idx),
        .wdata (nxt_val),
        .rdata (gpr_rd)
    );

    assign rdata = rd_en ? cur_val : '0;
endmodule

// File: rtl/bdm_core_chk.sv
module bdm_core_chk
    import bdm_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [DM_ADDR_W-1:0] addr,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [DM_DATA_W-1:0] wdata,
    input logic                 bit_set,
    input logic                 bit_clr,
    input logic [DM_BIT_W-1:0]  bit_sel,
    input logic [DM_DATA_W-1:0] rdata,
    input logic [DM_ADDR_W-1:0] mp0,
    input logic [DM_ADDR_W-1:0] mp1,
    input logic [DM_BANK_W-1:0] bank
);
    logic null_tgt;
    assign null_tgt = (addr == 8'h00 && (mp0 == 8'h00 || mp0 == 8'h02)) ||
                      (addr == 8'h02 && (mp1 == 8'h00 || mp1 == 8'h02));

    a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    a_r4_null_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && null_tgt) |-> rdata == '0);

    a_r5_null_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || bit_set || bit_clr) && null_tgt)
        |=> ($stable(mp0) && $stable(mp1) && $stable(bank)));

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h01) |=> mp0 == $past(wdata));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (bit_set || bit_clr) && addr == 8'h03) |=> mp1 == $past(wdata));

    a_r9_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && bit_set && addr == 8'h01)
        |=> mp0 == ($past(mp0) | (8'd1 << $past(bit_sel))));

    a_r10_bit_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !bit_set && bit_clr && addr == 8'h03)
        |=> mp1 == ($past(mp1) & ~(8'd1 << $past(bit_sel))));

    a_r3_window_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'h00 && mp0 == 8'h03) |-> rdata == mp1);
endmodule

bind bdm_core bdm_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .bit_set (bit_set),
    .bit_clr (bit_clr),
    .bit_sel (bit_sel),
    .rdata   (rdata),
    .mp0     (mp0_q),
    .mp1     (mp1_q),
    .bank    (bp_q)
);

// File: tb/tb_bdm_core.sv
module tb_bdm_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0, bit_set = 1'b0, bit_clr = 1'b0;
    logic [7:0] wdata = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_sfr [64];
    logic [7:0] m_gpr [3][192];

    always #4 clk = ~clk;

    bdm_core dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .bit_set(bit_set), .bit_clr(bit_clr), .bit_sel(bit_sel),
        .rdata(rdata)
    );

    function automatic int cur_bank();
        int b = int'(m_sfr[4][1:0]);
        return (b == 3) ? 0 : b;
    endfunction

    // Effective location of a direct address; -1 means no target.
    function automatic int eff_of(input logic [7:0] a);
        int e = int'(a);
        if (a == 8'h00)      e = int'(m_sfr[1]);
        else if (a == 8'h02) e = int'(m_sfr[3]);
        if (e == 0 || e == 2) return -1;
        return e;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        int e = eff_of(a);
        if (e < 0)  return 8'h00;
        if (e < 64) return m_sfr[e];
        return m_gpr[cur_bank()][e-64];
    endfunction

    function automatic void model_store(input logic [7:0] a, input logic [7:0] d);
        int e = eff_of(a);
        if (e < 0) return;
        if (e < 64) m_sfr[e] = d;
        else        m_gpr[cur_bank()][e-64] = d;
    endfunction

    function automatic logic [7:0] pat(input int b, input int a);
        return 8'(((a * 7) + (b * 53)) ^ 8'hA5);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        model_store(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic op(input logic [7:0] a, input logic w, input logic s, input logic c,
                      input logic [2:0] sel, input logic [7:0] d);
        logic [7:0] old;
        @(negedge clk);
        old = exp_read(a);
        addr = a; wr_en = w; bit_set = s; bit_clr = c; bit_sel = sel; wdata = d;
        if (w)      model_store(a, d);
        else if (s) model_store(a, old | (8'd1 << sel));
        else if (c) model_store(a, old & ~(8'd1 << sel));
        @(negedge clk);
        wr_en = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, rdata, exp_read(a));
        rd_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_sfr[i] = 8'h00;
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 192; i++) m_gpr[b][i] = 8'h00;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all special-function locations
        for (int a = 0; a < 64; a++) rd(8'(a), "R1");

        // R2: full 8-bit pointer registers
        for (int v = 0; v < 256; v += 17) begin
            wr(8'h01, 8'(v));       rd(8'h01, "R2");
            wr(8'h03, 8'(255 - v)); rd(8'h03, "R2");
        end

        // R6: fill all three banks, read back under each code
        for (int b = 0; b < 3; b++) begin
            wr(8'h04, 8'(b));
            for (int a = 64; a < 256; a++) wr(8'(a), pat(b, a));
        end
        for (int b = 0; b < 3; b++) begin
            wr(8'h04, 8'(b) | 8'hFC & 8'(b << 2));
            for (int a = 64; a < 256; a++) rd(8'(a), "R6");
        end
        wr(8'h04, 8'hF1);
        for (int a = 64; a < 256; a += 13) rd(8'(a), "R6");

        // R7: code 11 aliases bank 0
        wr(8'h04, 8'h03);
        for (int a = 64; a < 96; a++) wr(8'(a), 8'(a ^ 8'h3C));
        wr(8'h04, 8'h00);
        for (int a = 64; a < 96; a++) rd(8'(a), "R7");
        wr(8'h04, 8'h01);
        for (int a = 64; a < 96; a++) rd(8'(a), "R7");

        // R8: common storage below 40H
        for (int a = 5; a < 64; a++) wr(8'(a), 8'(a * 3 + 1));
        for (int b = 0; b < 4; b++) begin
            wr(8'h04, 8'(b));
            for (int a = 1; a < 64; a++) if (a != 2) rd(8'(a), "R8");
        end

        // R3/R4: every pointer value through both windows
        wr(8'h04, 8'h01);
        for (int v = 0; v < 256; v++) begin
            wr(8'h01, 8'(v));
            rd(8'h00, (v == 0 || v == 2) ? "R4" : "R3");
        end
        for (int v = 0; v < 256; v++) begin
            wr(8'h03, 8'(v));
            rd(8'h02, (v == 0 || v == 2) ? "R4" : "R3");
        end

        // R3: writes through windows
        wr(8'h01, 8'h20); wr(8'h00, 8'hC3); rd(8'h20, "R3");
        wr(8'h03, 8'h90); wr(8'h02, 8'h5E); rd(8'h90, "R3");

        // R13: window into banked region follows bank code
        wr(8'h04, 8'h02); wr(8'h03, 8'h80); wr(8'h02, 8'h77);
        rd(8'h80, "R13");
        wr(8'h04, 8'h00); rd(8'h02, "R13"); rd(8'h80, "R13");
        wr(8'h04, 8'h02); rd(8'h02, "R13");

        // R5: null writes through windows leave everything unchanged
        wr(8'h01, 8'h00); wr(8'h00, 8'h5A); op(8'h00, 1'b0, 1'b1, 1'b0, 3'd4, 8'h00);
        wr(8'h01, 8'h02); wr(8'h00, 8'hA5); op(8'h00, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00);
        wr(8'h03, 8'h00); wr(8'h02, 8'h3F);
        wr(8'h03, 8'h02); wr(8'h02, 8'hFF);
        for (int a = 1; a < 64; a++) if (a != 2) rd(8'(a), "R5");
        for (int a = 64; a < 256; a += 7) rd(8'(a), "R5");

        // R9/R10: single-bit set and clear, direct and through a window
        wr(8'h01, 8'hB0);
        for (int s = 0; s < 8; s++) begin
            op(8'h05, 1'b0, 1'b1, 1'b0, 3'(s), 8'h00); rd(8'h05, "R9");
            op(8'h41, 1'b0, 1'b1, 1'b0, 3'(s), 8'h00); rd(8'h41, "R9");
            op(8'h00, 1'b0, 1'b1, 1'b0, 3'(s), 8'h00); rd(8'hB0, "R9");
        end
        for (int s = 0; s < 8; s++) begin
            op(8'h05, 1'b0, 1'b0, 1'b1, 3'(s), 8'h00); rd(8'h05, "R10");
            op(8'h41, 1'b0, 1'b0, 1'b1, 3'(s), 8'h00); rd(8'h41, "R10");
            op(8'h00, 1'b0, 1'b0, 1'b1, 3'(s), 8'h00); rd(8'hB0, "R10");
        end

        // R11: strobe priority
        op(8'h06, 1'b1, 1'b1, 1'b1, 3'd2, 8'h81); rd(8'h06, "R11");
        op(8'h06, 1'b0, 1'b1, 1'b1, 3'd3, 8'h00); rd(8'h06, "R11");
        op(8'h06, 1'b1, 1'b0, 1'b1, 3'd0, 8'h10); rd(8'h06, "R11");

        // R12: idle read returns zero
        @(negedge clk);
        addr = 8'h06; rd_en = 1'b0;
        #1;
        check("R12", rdata, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule